// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers level-sensitive device requests into two CPU interrupt lines. Each of its two local groups has eight request inputs and an eight-bit enable mask. A third bank of eight mapped requests sits one level below. That bank is shared by both groups, and each group applies its own mapped mask to it. The OR of a group's masked mapped requests takes the place of one designated bit in that group's status, called the cascade bit. Through its two masks, a single mapped request can therefore raise either CPU line or both.

For each group the block drives a registered interrupt line. It also drives an encoded vector that names the single source software should service first. Inside a group, the highest-numbered pending bit has priority. When the cascade bit is pending, it overrides the group's local bits, and the vector then points into the mapped range. A small byte-wide register port lets software write the four masks and read them back, together with the three status views.

Top module: `casc_irq_ctrl`

## Requirements
- R1: A synchronous reset clears all four masks. In the cycle after reset is released, both interrupt lines are low, both vectors are 0 and both valid flags are low, whatever the request inputs are.
- R2: A source is pending only when its status bit and its mask bit are both 1. Group g's interrupt line is the OR of its pending bits, registered one clock after the inputs and masks.
- R3: Among the pending local bits of a group, the highest-numbered bit b wins. The vector is 1+b for group 0 and 9+b for group 1.
- R4: The cascade bit is bit 7 in group 0 and bit 3 in group 1. Its status equals the OR of the mapped requests ANDed with that group's mapped mask. The local request input at the cascade position is ignored.
- R5: When a group's cascade bit is pending, the vector comes from the masked mapped requests, whatever local bits are also pending. Its value is 17+b for group 0 and 25+b for group 1, where b is the highest masked mapped bit.
- R6: The two mapped masks act independently. One mapped request enabled in both masks is reported by both groups in the same cycle.
- R7: With nothing pending, a group's vector is 0 and its valid flag is low. The valid flag is high exactly when the vector is non-zero.
- R8: Register map, by byte address: 0 is group 0 status (read-only), 1 is group 0 mask, 2 is group 1 status (read-only), 3 is group 1 mask, 4 is mapped status (read-only), 5 is mapped mask 0, 6 is mapped mask 1, and 7 reads as zero. Writes to read-only addresses have no effect. The read data is registered and appears one clock after the address.
- R9: When a group's mask bit at the cascade position is 0, mapped requests cannot raise that group's line or change its vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lcl0_req | input | 8 | Level requests of local group 0 |
| lcl1_req | input | 8 | Level requests of local group 1 |
| map_req | input | 8 | Level requests of the shared mapped bank |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data for the previous cycle's address |
| irq0 | output | 1 | CPU interrupt line of group 0 |
| irq1 | output | 1 | CPU interrupt line of group 1 |
| vec0 | output | 6 | Encoded winning source of group 0 |
| vec0_vld | output | 1 | Vector 0 is non-zero |
| vec1 | output | 6 | Encoded winning source of group 1 |
| vec1_vld | output | 1 | Vector 1 is non-zero |

## Verification
Interrupt lines, vectors and valid flags are due at the first rising edge after new requests are applied. After a mask write, they are due one edge later, because the mask register captures the write first. Read data is due at the first edge after the address is presented. The bench drives every input on a falling edge. It finishes any mask write before it changes the requests, then samples shortly after the single rising edge at which the result is due, so each check sees exactly that edge's update.

// File: rtl/casc_irq_pkg.sv
package casc_irq_pkg;
  localparam int SRC_W   = 8;
  localparam int GROUPS  = 2;
  localparam int ADDR_W  = 3;
  localparam int VEC_W   = $clog2(2 * GROUPS * SRC_W + 1);

  typedef enum logic [ADDR_W-1:0] {
    RA_STAT0  = 3'd0,
    RA_MASK0  = 3'd1,
    RA_STAT1  = 3'd2,
    RA_MASK1  = 3'd3,
    RA_MSTAT  = 3'd4,
    RA_MMASK0 = 3'd5,
    RA_MMASK1 = 3'd6,
    RA_NONE   = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/casc_prio_enc.sv
module casc_prio_enc #(
  parameter int W  = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  bits,
  output logic [IW-1:0] idx,
  output logic          hit
);
  // later (higher) indices overwrite earlier ones: highest set bit wins
  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (bits[i]) idx = IW'(i);
    end
    hit = |bits;
  end
endmodule

// File: rtl/casc_group.sv
module casc_group #(
  parameter int W          = 8,
  parameter int CASC_BIT   = 7,
  parameter int LOCAL_BASE = 0,
  parameter int MAP_BASE   = 16,
  parameter int VW         = 6,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req,
  input  logic [W-1:0]  mask,
  input  logic [W-1:0]  map_stat,
  input  logic [W-1:0]  map_mask,
  output logic [W-1:0]  stat,
  output logic          any,
  output logic [VW-1:0] vec
);
  logic [W-1:0]  map_pend;
  logic [W-1:0]  pend;
  logic [IW-1:0] loc_idx, map_idx;
  logic          loc_hit, map_hit;

  assign map_pend = map_stat & map_mask;

  always_comb begin
    stat           = req;
    stat[CASC_BIT] = |map_pend;
  end

  assign pend = stat & mask;
  assign any  = |pend;

  casc_prio_enc #(.W(W)) u_loc (.bits(pend),     .idx(loc_idx), .hit(loc_hit));
  casc_prio_enc #(.W(W)) u_map (.bits(map_pend), .idx(map_idx), .hit(map_hit));

  always_comb begin
    if (pend[CASC_BIT] && map_hit)
      vec = VW'(MAP_BASE) + VW'(map_idx) + VW'(1);
    else if (loc_hit)
      vec = VW'(LOCAL_BASE) + VW'(loc_idx) + VW'(1);
    else
      vec = '0;
  end
endmodule

// File: rtl/casc_regs.sv
module casc_regs
  import casc_irq_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  stat0,
  input  logic [W-1:0]  stat1,
  input  logic [W-1:0]  mstat,
  output logic [W-1:0]  mask0,
  output logic [W-1:0]  mask1,
  output logic [W-1:0]  mmask0,
  output logic [W-1:0]  mmask1,
  output logic [W-1:0]  rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask0  <= '0;
      mask1  <= '0;
      mmask0 <= '0;
      mmask1 <= '0;
    end else if (wr_en) begin
      case (addr)
        RA_MASK0:  mask0  <= wdata;
        RA_MASK1:  mask1  <= wdata;
        RA_MMASK0: mmask0 <= wdata;
        RA_MMASK1: mmask1 <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        RA_STAT0:  rdata <= stat0;
        RA_MASK0:  rdata <= mask0;
        RA_STAT1:  rdata <= stat1;
        RA_MASK1:  rdata <= mask1;
        RA_MSTAT:  rdata <= mstat;
        RA_MMASK0: rdata <= mmask0;
        RA_MMASK1: rdata <= mmask1;
        default:   rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl
  import casc_irq_pkg::*;
#(
  parameter int W         = SRC_W,
  parameter int AW        = ADDR_W,
  parameter int CASC0_BIT = 7,
  parameter int CASC1_BIT = 3,
  localparam int NG = 2,
  localparam int VW = $clog2(2 * NG * W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  lcl0_req,
  input  logic [W-1:0]  lcl1_req,
  input  logic [W-1:0]  map_req,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic          irq0,
  output logic          irq1,
  output logic [VW-1:0] vec0,
  output logic          vec0_vld,
  output logic [VW-1:0] vec1,
  output logic          vec1_vld
);
  logic [W-1:0]  req_a   [NG];
  logic [W-1:0]  mask_a  [NG];
  logic [W-1:0]  mmask_a [NG];
  logic [W-1:0]  stat_a  [NG];
  logic          any_a   [NG];
  logic [VW-1:0] vec_a   [NG];
  logic          irq_q   [NG];
  logic [VW-1:0] vec_q   [NG];
  logic          vld_q   [NG];

  assign req_a[0] = lcl0_req;
  assign req_a[1] = lcl1_req;

  casc_regs #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .stat0(stat_a[0]), .stat1(stat_a[1]), .mstat(map_req),
    .mask0(mask_a[0]), .mask1(mask_a[1]),
    .mmask0(mmask_a[0]), .mmask1(mmask_a[1]),
    .rdata(rdata)
  );

  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam int CB = (g == 0) ? CASC0_BIT : CASC1_BIT;

    casc_group #(
      .W(W), .CASC_BIT(CB), .LOCAL_BASE(g * W),
      .MAP_BASE((NG + g) * W), .VW(VW)
    ) u_grp (
      .req(req_a[g]), .mask(mask_a[g]),
      .map_stat(map_req), .map_mask(mmask_a[g]),
      .stat(stat_a[g]), .any(any_a[g]), .vec(vec_a[g])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        irq_q[g] <= 1'b0;
        vec_q[g] <= '0;
        vld_q[g] <= 1'b0;
      end else begin
        irq_q[g] <= any_a[g];
        vec_q[g] <= vec_a[g];
        vld_q[g] <= (vec_a[g] != '0);
      end
    end
  end

  assign irq0     = irq_q[0];
  assign irq1     = irq_q[1];
  assign vec0     = vec_q[0];
  assign vec1     = vec_q[1];
  assign vec0_vld = vld_q[0];
  assign vec1_vld = vld_q[1];
endmodule

// File: rtl/casc_irq_chk.sv
module casc_irq_chk #(
  parameter int W  = 8,
  parameter int VW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          irq0,
  input logic          irq1,
  input logic [VW-1:0] vec0,
  input logic          vec0_vld,
  input logic [VW-1:0] vec1,
  input logic          vec1_vld
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq0 && !irq1 && !vec0_vld && !vec1_vld)); // R1

  AST_VLD0_CODE: assert property (@(posedge clk) disable iff (rst)
    vec0_vld == (vec0 != '0)); // R7

  AST_VLD1_CODE: assert property (@(posedge clk) disable iff (rst)
    vec1_vld == (vec1 != '0)); // R7

  AST_IRQ0_HAS_VEC: assert property (@(posedge clk) disable iff (rst)
    irq0 == vec0_vld); // R2

  AST_IRQ1_HAS_VEC: assert property (@(posedge clk) disable iff (rst)
    irq1 == vec1_vld); // R2

  AST_VEC0_RANGE: assert property (@(posedge clk) disable iff (rst)
    vec0_vld |-> ((vec0 >= VW'(1) && vec0 <= VW'(W)) ||
                  (vec0 >= VW'(2*W+1) && vec0 <= VW'(3*W)))); // R5

  AST_VEC1_RANGE: assert property (@(posedge clk) disable iff (rst)
    vec1_vld |-> ((vec1 >= VW'(W+1) && vec1 <= VW'(2*W)) ||
                  (vec1 >= VW'(3*W+1) && vec1 <= VW'(4*W)))); // R3
endmodule

bind casc_irq_ctrl casc_irq_chk #(.W(W), .VW(VW)) u_chk (
  .clk(clk), .rst(rst), .irq0(irq0), .irq1(irq1),
  .vec0(vec0), .vec0_vld(vec0_vld), .vec1(vec1), .vec1_vld(vec1_vld)
);

// File: tb/casc_irq_ctrl_test.sv
`timescale 1ns/1ps
module casc_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] lcl0_req = '0, lcl1_req = '0, map_req = '0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq0, irq1, vec0_vld, vec1_vld;
  logic [5:0] vec0, vec1;

  int tests = 0;
  int fails = 0;

  // bench copy of the masks, tracked from its own writes
  logic [7:0] m0 = '0, m1 = '0, mm0 = '0, mm1 = '0;

  always #2.5 clk = ~clk;

  casc_irq_ctrl uut (
    .clk(clk), .rst(rst), .lcl0_req(lcl0_req), .lcl1_req(lcl1_req),
    .map_req(map_req), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq0(irq0), .irq1(irq1), .vec0(vec0),
    .vec0_vld(vec0_vld), .vec1(vec1), .vec1_vld(vec1_vld)
  );

  task automatic chk(input string tag, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int hi_bit(input logic [7:0] v);
    int r = -1;
    for (int i = 0; i < 8; i++) if (v[i]) r = i;
    return r;
  endfunction

  function automatic logic [7:0] ref_stat(input int g);
    logic [7:0] s = (g == 0) ? lcl0_req : lcl1_req;
    logic [7:0] mm = (g == 0) ? mm0 : mm1;
    s[(g == 0) ? 7 : 3] = |(map_req & mm);
    return s;
  endfunction

  function automatic int ref_vec(input int g);
    logic [7:0] pend = ref_stat(g) & ((g == 0) ? m0 : m1);
    logic [7:0] mp = map_req & ((g == 0) ? mm0 : mm1);
    if (pend[(g == 0) ? 7 : 3]) return 17 + 8 * g + hi_bit(mp);
    if (pend != 0) return 1 + 8 * g + hi_bit(pend);
    return 0;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      3'd1: m0 = d;
      3'd3: m1 = d;
      3'd5: mm0 = d;
      3'd6: mm1 = d;
      default: ;
    endcase
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input int exp);
    @(negedge clk);
    addr = a;
    @(posedge clk); #1;
    chk(tag, rdata, exp);
  endtask

  // apply requests at a falling edge, sample just after the next rising edge
  task automatic drive_and_check(input string tag, input logic [7:0] l0,
                                 input logic [7:0] l1, input logic [7:0] mr);
    @(negedge clk);
    lcl0_req = l0; lcl1_req = l1; map_req = mr;
    @(posedge clk); #1;
    chk({tag, " vec0"}, vec0, ref_vec(0));
    chk({tag, " vec1"}, vec1, ref_vec(1));
    chk({tag, " irq0"}, irq0, ref_vec(0) != 0);
    chk({tag, " irq1"}, irq1, ref_vec(1) != 0);
    chk({tag, " vld0 R7"}, vec0_vld, ref_vec(0) != 0);
  endtask

  task automatic t_reset;
    lcl0_req = 8'hFF; lcl1_req = 8'hFF; map_req = 8'hFF;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 irq0 after reset", irq0, 0);
    chk("R1 irq1 after reset", irq1, 0);
    chk("R1 vec0 after reset", vec0, 0);
    chk("R1 vec1_vld after reset", vec1_vld, 0);
    rd_chk("R1 mask0 cleared", 3'd1, 0);
    rd_chk("R1 mapped mask1 cleared", 3'd6, 0);
  endtask

  task automatic t_local_prio;
    wr(3'd1, 8'hFF); wr(3'd3, 8'hFF);
    drive_and_check("R3 local priority", 8'h25, 8'h13, 8'h00);
    chk("R3 vec0 value", vec0, 6);
    chk("R3 vec1 value", vec1, 13);
    drive_and_check("R2 masked off", 8'h00, 8'h00, 8'h00);
    wr(3'd1, 8'h02);
    drive_and_check("R2 mask filters", 8'h41, 8'h00, 8'h00);
    chk("R2 irq0 low", irq0, 0);
    drive_and_check("R3 lowest bit", 8'h03, 8'h01, 8'h00);
    chk("R3 vec1 bit0", vec1, 9);
  endtask

  task automatic t_cascade_ignore;
    wr(3'd1, 8'h80); wr(3'd5, 8'h00);
    drive_and_check("R4 local cascade input ignored", 8'h80, 8'h00, 8'h00);
    chk("R4 irq0 stays low", irq0, 0);
    rd_chk("R4 status0 cascade bit clear", 3'd0, 8'h00);
    wr(3'd5, 8'h01);
    drive_and_check("R4 cascade from mapped", 8'h00, 8'h00, 8'h01);
    rd_chk("R4 status0 cascade bit set", 3'd0, 8'h80);
    chk("R4 vec0 mapped", vec0, 17);
  endtask

  task automatic t_cascade_route;
    wr(3'd1, 8'h81); wr(3'd5, 8'hFF);
    wr(3'd3, 8'h08); wr(3'd6, 8'h04);
    drive_and_check("R5 cascade overrides", 8'h01, 8'h00, 8'h24);
    chk("R5 vec0 value", vec0, 22);
    chk("R6 vec1 shared route", vec1, 27);
    wr(3'd1, 8'h01);
    drive_and_check("R9 cascade masked", 8'h01, 8'h00, 8'h24);
    chk("R9 vec0 local only", vec0, 1);
    wr(3'd1, 8'h00); wr(3'd3, 8'h00);
    drive_and_check("R7 nothing pending", 8'hFF, 8'hFF, 8'hFF);
    chk("R7 vec1_vld low", vec1_vld, 0);
  endtask

  task automatic t_regs;
    wr(3'd0, 8'hFF); wr(3'd2, 8'hFF); wr(3'd4, 8'hFF);
    wr(3'd6, 8'hA5);
    @(negedge clk); lcl0_req = 8'h11; lcl1_req = 8'h22; map_req = 8'h00;
    rd_chk("R8 status0 readonly", 3'd0, 8'h11);
    rd_chk("R8 status1 readonly", 3'd2, 8'h22);
    rd_chk("R8 mapped mask1 rw", 3'd6, 8'hA5);
    rd_chk("R8 addr7 zero", 3'd7, 0);
    @(negedge clk); map_req = 8'h5A;
    rd_chk("R8 mapped status", 3'd4, 8'h5A);
  endtask

  task automatic t_random;
    for (int n = 0; n < 60; n++) begin
      wr(3'd1, 8'($urandom)); wr(3'd3, 8'($urandom));
      wr(3'd5, 8'($urandom)); wr(3'd6, 8'($urandom));
      drive_and_check("R6 random", 8'($urandom), 8'($urandom), 8'($urandom));
    end
  endtask

  initial begin
    t_reset();
    t_local_prio();
    t_cascade_ignore();
    t_cascade_route();
    t_regs();
    t_random();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule